// File: doc/BRIEF.md
# Privileged Virtual Segment Address Decoder

This block turns a 32-bit virtual address into a physical address for a processor with three privilege levels. The top three address bits pick one of five segments: a large low segment open to every mode, two directly translated kernel windows (one for cached, one for uncached access), a supervisor window and a kernel-only mapped window. The current privilege mode and an error-level status bit decide, for each segment, whether the address is translated by a fixed offset, handed to an external TLB for lookup, or refused.

A request is taken when `req_valid` is high and `req_ready` is high. Unmapped and refused requests produce a registered result on the next cycle. Mapped requests raise a TLB lookup request that stays up until the TLB answers. The result is registered one cycle after that answer and carries the TLB's translation and permissions. A strap selects a second, fixed-mapping mode in which no address is ever refused and the TLB is never used.

Top module: `vseg_xlate`

## Requirements
- R1: With `fixed_map`=0 and `err_level`=1, any address below 0x80000000 returns itself as the physical address, with read and write granted and result code 3'b000, in every privilege mode.
- R2: With `fixed_map`=0 and `err_level`=0, an address below 0x80000000 raises a TLB request that carries the address and the write flag, in every privilege mode.
- R3: An address in 0x80000000–0x9FFFFFFF in kernel mode returns the address minus 0x80000000, read and write granted, code 3'b000.
- R4: An address in 0xA0000000–0xBFFFFFFF in kernel mode returns the address minus 0xA0000000, read and write granted, code 3'b000.
- R5: An address in 0xC0000000–0xDFFFFFFF in supervisor or kernel mode raises a TLB request.
- R6: An address at or above 0xE0000000 in kernel mode raises a TLB request.
- R7: With `fixed_map`=0, a non-kernel access at or above 0x80000000 that is not allowed by R5 returns code 3'b111 (bad address), physical address 0, no permissions, and raises no TLB request.
- R8: Result codes are signed 3-bit values: 0 success, -1 bad address, -2 no TLB match, -3 entry invalid, -4 write to clean page. A TLB answer is forwarded with its code; on success its address and permissions pass through, otherwise address and permissions read as 0.
- R9: With `fixed_map`=1, an address below 0x80000000 returns the address plus 0x40000000 when `err_level`=0 and the address itself when `err_level`=1. Read and write are granted and the code is 3'b000.
- R10: With `fixed_map`=1, an address in 0x80000000–0xBFFFFFFF returns its low 29 bits, and a higher address returns itself. Read and write are granted and the code is 3'b000 in every mode.
- R11: A direct or refused result has `out_valid` high in the cycle after acceptance. A TLB request is high from the cycle after acceptance until the cycle in which `tlb_rsp_valid` is seen, and `out_valid` follows one cycle after that.
- R12: While a TLB lookup is pending, `req_ready` is low, and a request on the input is ignored: the pending TLB address and the final result are unchanged.
- R13: `priv_mode` encoding: 2'b10 user, 2'b01 supervisor, 2'b00 and 2'b11 both kernel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_map | input | 1 | Strap: 1 selects fixed-mapping mode |
| err_level | input | 1 | Error-level status bit |
| priv_mode | input | 2 | Current privilege mode |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| tlb_req_valid | output | 1 | TLB lookup pending |
| tlb_req_vaddr | output | 32 | Address to look up |
| tlb_req_write | output | 1 | Lookup is for a write |
| tlb_rsp_valid | input | 1 | TLB answer present |
| tlb_rsp_code | input | 3 | TLB result code |
| tlb_rsp_paddr | input | 32 | TLB physical address |
| tlb_rsp_rd | input | 1 | TLB read permission |
| tlb_rsp_wr | input | 1 | TLB write permission |
| out_valid | output | 1 | Result present |
| out_paddr | output | 32 | Physical address |
| out_rd | output | 1 | Read permitted |
| out_wr | output | 1 | Write permitted |
| out_code | output | 3 | Result code |

## Verification
The sweep covers every segment at its first and last byte and at interior offsets, in all four mode encodings, both error-level values, both straps and both access directions. A decoder that treats mode 2'b11 as user would refuse kernel windows. One that ignores the error-level override would send the low segment to the TLB. One that uses a subtraction constant that is off would show a shifted address at the window edges. The TLB model answers after zero, one or two cycles with each failure code. A second request during a slow lookup checks that pending state is not disturbed. A design that leaks a failing TLB's address, or that drops the lookup request early, produces a different result.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [1:0] {
    RT_DIRECT = 2'd0,
    RT_MAPPED = 2'd1,
    RT_REJECT = 2'd2
  } route_e;

  localparam logic [2:0] RC_OK      = 3'b000;
  localparam logic [2:0] RC_BADADDR = 3'b111;
  localparam logic [2:0] RC_MISS    = 3'b110;
  localparam logic [2:0] RC_INVALID = 3'b101;
  localparam logic [2:0] RC_DIRTY   = 3'b100;

  localparam logic [1:0] PM_SUPER = 2'b01;
  localparam logic [1:0] PM_USER  = 2'b10;
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify import vseg_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  input  logic              fixed_map,
  output route_e            route,
  output logic [ADDR_W-1:0] direct_paddr
);
  localparam int SEG_LSB = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] FIX_OFS = {2'b01, {(ADDR_W-2){1'b0}}};

  logic is_kern;
  logic is_super;
  logic [ADDR_W-1:0] window_pa;

  assign is_super  = (priv_mode == PM_SUPER);
  assign is_kern   = !is_super && (priv_mode != PM_USER);
  assign window_pa = {3'b000, vaddr[SEG_LSB-1:0]};

  always_comb begin
    route        = RT_DIRECT;
    direct_paddr = '0;
    if (fixed_map) begin
      if (!vaddr[ADDR_W-1]) begin
        direct_paddr = err_level ? vaddr : vaddr + FIX_OFS;
      end else if (!vaddr[ADDR_W-2]) begin
        direct_paddr = window_pa;
      end else begin
        direct_paddr = vaddr;
      end
    end else begin
      case (vaddr[ADDR_W-1:SEG_LSB])
        3'd4, 3'd5: begin
          route        = is_kern ? RT_DIRECT : RT_REJECT;
          direct_paddr = is_kern ? window_pa : '0;
        end
        3'd6: route = (is_kern || is_super) ? RT_MAPPED : RT_REJECT;
        3'd7: route = is_kern ? RT_MAPPED : RT_REJECT;
        default: begin
          route        = err_level ? RT_DIRECT : RT_MAPPED;
          direct_paddr = err_level ? vaddr : '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/vseg_rsp_fmt.sv
module vseg_rsp_fmt import vseg_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        rsp_code,
  input  logic [ADDR_W-1:0] rsp_paddr,
  input  logic              rsp_rd,
  input  logic              rsp_wr,
  output logic [2:0]        fmt_code,
  output logic [ADDR_W-1:0] fmt_paddr,
  output logic              fmt_rd,
  output logic              fmt_wr
);
  logic hit;
  assign hit       = (rsp_code == RC_OK);
  assign fmt_code  = rsp_code;
  assign fmt_paddr = hit ? rsp_paddr : '0;
  assign fmt_rd    = hit && rsp_rd;
  assign fmt_wr    = hit && rsp_wr;
endmodule

// File: rtl/vseg_ctrl.sv
module vseg_ctrl import vseg_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  route_e            route,
  input  logic [ADDR_W-1:0] direct_paddr,
  input  logic              tlb_rsp_valid,
  input  logic [2:0]        fmt_code,
  input  logic [ADDR_W-1:0] fmt_paddr,
  input  logic              fmt_rd,
  input  logic              fmt_wr,
  output logic              req_ready,
  output logic              tlb_req_valid,
  output logic [ADDR_W-1:0] tlb_req_vaddr,
  output logic              tlb_req_write,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_paddr,
  output logic              out_rd,
  output logic              out_wr,
  output logic [2:0]        out_code
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;

  st_e               st_q, st_d;
  logic              accept, tlb_done, lkp_en, res_en;
  logic [ADDR_W-1:0] lkp_addr_q, res_paddr_d, res_paddr_q;
  logic              lkp_wr_q, res_rd_d, res_rd_q, res_wr_d, res_wr_q, vld_q;
  logic [2:0]        res_code_d, res_code_q;

  assign accept   = req_valid && (st_q == ST_IDLE);
  assign tlb_done = (st_q == ST_WAIT) && tlb_rsp_valid;
  assign lkp_en   = accept && (route == RT_MAPPED);
  assign res_en   = tlb_done || (accept && (route != RT_MAPPED));

  always_comb begin
    st_d = st_q;
    if (lkp_en)   st_d = ST_WAIT;
    if (tlb_done) st_d = ST_IDLE;
  end

  always_comb begin
    res_paddr_d = fmt_paddr;
    res_rd_d    = fmt_rd;
    res_wr_d    = fmt_wr;
    res_code_d  = fmt_code;
    if (!tlb_done) begin
      res_paddr_d = (route == RT_DIRECT) ? direct_paddr : '0;
      res_rd_d    = (route == RT_DIRECT);
      res_wr_d    = (route == RT_DIRECT);
      res_code_d  = (route == RT_DIRECT) ? RC_OK : RC_BADADDR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= res_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lkp_addr_q <= '0;
      lkp_wr_q   <= 1'b0;
    end else if (lkp_en) begin
      lkp_addr_q <= req_vaddr;
      lkp_wr_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_paddr_q <= '0;
      res_rd_q    <= 1'b0;
      res_wr_q    <= 1'b0;
      res_code_q  <= RC_OK;
    end else if (res_en) begin
      res_paddr_q <= res_paddr_d;
      res_rd_q    <= res_rd_d;
      res_wr_q    <= res_wr_d;
      res_code_q  <= res_code_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign tlb_req_valid = (st_q == ST_WAIT);
  assign tlb_req_vaddr = lkp_addr_q;
  assign tlb_req_write = lkp_wr_q;
  assign out_valid     = vld_q;
  assign out_paddr     = res_paddr_q;
  assign out_rd        = res_rd_q;
  assign out_wr        = res_wr_q;
  assign out_code      = res_code_q;
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate import vseg_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_map,
  input  logic              err_level,
  input  logic [1:0]        priv_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              tlb_req_valid,
  output logic [ADDR_W-1:0] tlb_req_vaddr,
  output logic              tlb_req_write,
  input  logic              tlb_rsp_valid,
  input  logic [2:0]        tlb_rsp_code,
  input  logic [ADDR_W-1:0] tlb_rsp_paddr,
  input  logic              tlb_rsp_rd,
  input  logic              tlb_rsp_wr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_paddr,
  output logic              out_rd,
  output logic              out_wr,
  output logic [2:0]        out_code
);
  route_e            route;
  logic [ADDR_W-1:0] direct_paddr, fmt_paddr;
  logic [2:0]        fmt_code;
  logic              fmt_rd, fmt_wr;

  vseg_classify #(.ADDR_W(ADDR_W)) cls_i (
    .vaddr(req_vaddr), .priv_mode(priv_mode), .err_level(err_level),
    .fixed_map(fixed_map), .route(route), .direct_paddr(direct_paddr)
  );

  vseg_rsp_fmt #(.ADDR_W(ADDR_W)) fmt_i (
    .rsp_code(tlb_rsp_code), .rsp_paddr(tlb_rsp_paddr), .rsp_rd(tlb_rsp_rd),
    .rsp_wr(tlb_rsp_wr), .fmt_code(fmt_code), .fmt_paddr(fmt_paddr),
    .fmt_rd(fmt_rd), .fmt_wr(fmt_wr)
  );

  vseg_ctrl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .route(route), .direct_paddr(direct_paddr),
    .tlb_rsp_valid(tlb_rsp_valid), .fmt_code(fmt_code), .fmt_paddr(fmt_paddr),
    .fmt_rd(fmt_rd), .fmt_wr(fmt_wr), .req_ready(req_ready),
    .tlb_req_valid(tlb_req_valid), .tlb_req_vaddr(tlb_req_vaddr),
    .tlb_req_write(tlb_req_write), .out_valid(out_valid), .out_paddr(out_paddr),
    .out_rd(out_rd), .out_wr(out_wr), .out_code(out_code)
  );
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fixed_map,
  input logic [1:0]        priv_mode,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              tlb_req_valid,
  input logic [ADDR_W-1:0] tlb_req_vaddr,
  input logic              tlb_rsp_valid,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_paddr,
  input logic              out_rd,
  input logic              out_wr,
  input logic [2:0]        out_code
);
  // R11
  lookup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid && !tlb_rsp_valid |=> tlb_req_valid && $stable(tlb_req_vaddr));

  // R11
  rsp_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid && tlb_rsp_valid |=> out_valid && !tlb_req_valid);

  // R11
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (out_valid != tlb_req_valid));

  // R8
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_code != 3'b000) |-> (out_paddr == '0) && !out_rd && !out_wr);

  // R7
  user_kernel_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !fixed_map && (priv_mode == 2'b10) && req_vaddr[ADDR_W-1]
    |=> out_valid && (out_code == 3'b111) && !tlb_req_valid);

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid |-> !req_ready);
endmodule

bind vseg_xlate vseg_xlate_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fixed_map(fixed_map), .priv_mode(priv_mode),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .tlb_req_valid(tlb_req_valid), .tlb_req_vaddr(tlb_req_vaddr),
  .tlb_rsp_valid(tlb_rsp_valid), .out_valid(out_valid), .out_paddr(out_paddr),
  .out_rd(out_rd), .out_wr(out_wr), .out_code(out_code)
);

// File: tb/vseg_xlate_tb_top.sv
`timescale 1ns/1ps
module vseg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_map = 1'b0, err_level = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  priv_mode = 2'b00;
  logic [31:0] req_vaddr = '0;
  logic        tlb_rsp_valid = 1'b0, tlb_rsp_rd = 1'b0, tlb_rsp_wr = 1'b0;
  logic [2:0]  tlb_rsp_code = '0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic        req_ready, tlb_req_valid, tlb_req_write, out_valid, out_rd, out_wr;
  logic [31:0] tlb_req_vaddr, out_paddr;
  logic [2:0]  out_code;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vseg_xlate #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .fixed_map(fixed_map), .err_level(err_level),
    .priv_mode(priv_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .tlb_req_valid(tlb_req_valid),
    .tlb_req_vaddr(tlb_req_vaddr), .tlb_req_write(tlb_req_write),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code),
    .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_rd(tlb_rsp_rd), .tlb_rsp_wr(tlb_rsp_wr),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_rd(out_rd), .out_wr(out_wr),
    .out_code(out_code)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // route: 0 direct, 1 TLB, 2 refused
  function automatic void model(input logic [31:0] va, input logic [1:0] md, input bit el,
                                input bit fx, output int rt, output logic [31:0] pa);
    bit kern, sup;
    kern = (md == 2'b00) || (md == 2'b11);   // R13
    sup  = (md == 2'b01);
    rt = 0; pa = 32'h0;
    if (fx) begin
      if (va < 32'h8000_0000) pa = el ? va : va + 32'h4000_0000;
      else if (va < 32'hC000_0000) pa = va & 32'h1FFF_FFFF;
      else pa = va;
    end else if (va < 32'h8000_0000) begin
      if (el) pa = va; else rt = 1;
    end else if (va < 32'hA000_0000) begin
      if (kern) pa = va - 32'h8000_0000; else rt = 2;
    end else if (va < 32'hC000_0000) begin
      if (kern) pa = va - 32'hA000_0000; else rt = 2;
    end else if (va < 32'hE000_0000) begin
      rt = (kern || sup) ? 1 : 2;
    end else begin
      rt = kern ? 1 : 2;
    end
  endfunction

  function automatic string tag_of(input logic [31:0] va, input bit el, input bit fx, input int rt);
    if (fx) return va[31] ? "R10" : "R9";
    if (rt == 2) return "R7";
    case (va[31:29])
      3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return el ? "R1" : "R2";
    endcase
  endfunction

  initial begin
    logic [31:0] offs [4];
    int vec = 0;
    offs[0] = 32'h0; offs[1] = 32'h1FFF_FFFF; offs[2] = 32'h00AB_CDE6; offs[3] = 32'h0135_79BD;
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready && !tlb_req_valid && !out_valid, "reset", {tlb_req_valid, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 8; s++)
    for (int k = 0; k < 4; k++)
    for (int m = 0; m < 4; m++)
    for (int e = 0; e < 2; e++)
    for (int f = 0; f < 2; f++)
    for (int w = 0; w < 2; w++) begin
      logic [31:0] va, epa;
      int rt, lat;
      string tg;
      va = {s[2:0], 29'h0} | offs[k];
      model(va, m[1:0], e[0], f[0], rt, epa);
      tg = tag_of(va, e[0], f[0], rt);
      if (m == 3) tg = {tg, " R13"};
      lat = vec % 3;
      vec++;
      @(negedge clk);
      fixed_map = f[0]; err_level = e[0]; priv_mode = m[1:0];
      req_vaddr = va; req_write = w[0]; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (rt != 1) begin
        logic [31:0] xpa;
        xpa = (rt == 0) ? epa : 32'h0;
        chk(out_valid && !tlb_req_valid, {tg, " R11 direct timing"}, {out_valid, tlb_req_valid}, 64'h2);
        chk(out_paddr == xpa && out_rd == (rt == 0) && out_wr == (rt == 0) &&
            out_code == ((rt == 0) ? 3'b000 : 3'b111), tg,
            {out_code, out_rd, out_wr, out_paddr}, {(rt == 0) ? 3'b000 : 3'b111, rt == 0, rt == 0, xpa});
      end else begin
        logic [2:0]  ecode;
        logic [31:0] tpa;
        chk(tlb_req_valid && !out_valid && tlb_req_vaddr == va && tlb_req_write == w[0],
            {tg, " R11 lookup"}, {tlb_req_valid, out_valid, tlb_req_write, tlb_req_vaddr},
            {2'b10, w[0], va});
        if (lat == 2) begin
          // R12: stray request while busy
          chk(!req_ready, "R12 ready", {63'h0, req_ready}, 64'h0);
          req_vaddr = ~va; req_write = ~w[0]; req_valid = 1'b1;
        end
        for (int c = 0; c < lat; c++) begin
          @(negedge clk);
          req_valid = 1'b0; req_vaddr = va; req_write = w[0];
          chk(tlb_req_valid && !out_valid && tlb_req_vaddr == va && tlb_req_write == w[0],
              "R12 R11 pending", {tlb_req_valid, out_valid, tlb_req_write, tlb_req_vaddr},
              {2'b10, w[0], va});
        end
        case (va[1:0])
          2'd0: ecode = 3'b000;
          2'd1: ecode = 3'b110;
          2'd2: ecode = 3'b101;
          default: ecode = 3'b100;
        endcase
        tpa = {~va[31:12], va[11:0]};
        tlb_rsp_valid = 1'b1; tlb_rsp_code = ecode; tlb_rsp_paddr = tpa;
        tlb_rsp_rd = 1'b1; tlb_rsp_wr = va[2];
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
        chk(out_valid && !tlb_req_valid, {tg, " R11 response timing"}, {out_valid, tlb_req_valid}, 64'h2);
        if (ecode == 3'b000)
          chk(out_code == 3'b000 && out_paddr == tpa && out_rd && out_wr == va[2], {tg, " R8"},
              {out_code, out_rd, out_wr, out_paddr}, {3'b000, 1'b1, va[2], tpa});
        else
          chk(out_code == ecode && out_paddr == 32'h0 && !out_rd && !out_wr, {tg, " R8"},
              {out_code, out_rd, out_wr, out_paddr}, {ecode, 2'b00, 32'h0});
      end
    end
    finish_run();
  end
endmodule